// File: doc/BRIEF.md
# Pixel Frame Load Sequencer

This controller moves one complete frame into a two-dimensional array of pixel drivers. A frame is either a binary on/off pattern (one bit per pixel) or a grey-level frame (GREY_BITS bits per pixel, five by default). Frame bits arrive one per beat on a valid/ready stream. The sequencer turns them into per-pixel write strobes with row and column addresses, a write-target select and a data bit. For grey-level frames it also issues the shift strobes that fill a pixel's level register bit by bit, followed by one load strobe that writes the completed level.

A load begins with a start pulse that carries the frame kind and the commit mode. In rolling mode every pixel becomes visible on its own write. In global mode nothing is shown until the last pixel is written, and then a single commit strobe presents the whole frame. A one-cycle done pulse ends every load. An activity clock runs only while a load is in progress, so downstream driver logic sees edges only when frame data is moving.

Top module: `frame_load_seq`

## Requirements
- R1: After reset, s_ready_o, busy_o, act_clk_o, pix_we_o, lvl_shift_o, pix_show_o, commit_o and done_o are all 0.
- R2: Binary load (grey_i=0 at start): each accepted beat produces one pix_we_o pulse in the next cycle. That pulse carries tgt_lvl_o=0 (pattern memory) and wr_bit_o equal to the beat's bit. Addresses run row-major, with the column changing fastest, from (0,0) to (ROWS-1,COLS-1), for exactly ROWS*COLS writes.
- R3: Grey load (grey_i=1 at start): each pixel takes GREY_BITS beats, most significant bit first. Each beat produces one lvl_shift_o pulse in the next cycle, with wr_bit_o equal to the beat's bit. The pixel's pix_we_o pulse (the level load strobe, tgt_lvl_o=1, meaning level registers) follows in the cycle right after its last shift pulse.
- R4: With a continuously valid stream, consecutive pixel writes are 1 cycle apart in a binary load and GREY_BITS+1 cycles apart in a grey load.
- R5: s_ready_o is 0 while idle, and during the overhead cycle that precedes each grey pixel write. Beats offered while idle produce no strobes.
- R6: In rolling mode (global_i=0 at start), pix_show_o pulses together with every pix_we_o and commit_o never pulses.
- R7: In global mode (global_i=1 at start), pix_show_o never pulses. Exactly one commit_o pulse comes one cycle after the last pixel write, and done_o comes one cycle after commit_o.
- R8: In rolling mode, done_o pulses one cycle after the last pixel write.
- R9: act_clk_o inverts on every cycle that follows a busy cycle, and is 0 on every cycle that follows a non-busy cycle.
- R10: Gaps in s_valid_i pause the load without losing, repeating or reordering data.
- R11: A start pulse during a load is ignored. Frame kind and commit mode stay as latched, and only one done pulse is produced.
- R12: busy_o is 1 from the cycle after an accepted start until done_o. done_o lasts one cycle and busy_o is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| grey_i | input | 1 | Frame kind at start: 1 grey-level, 0 binary |
| global_i | input | 1 | Commit mode at start: 1 global, 0 rolling |
| s_valid_i | input | 1 | Stream beat valid |
| s_data_i | input | 1 | Stream beat data bit |
| s_ready_o | output | 1 | Stream ready |
| pix_we_o | output | 1 | Pixel write strobe (level load strobe in grey frames) |
| pix_row_o | output | idx_w(ROWS) | Row address of the pixel write |
| pix_col_o | output | idx_w(COLS) | Column address of the pixel write |
| wr_bit_o | output | 1 | Data bit for a binary write or a level shift |
| tgt_lvl_o | output | 1 | Write target: 1 level registers, 0 pattern memory |
| lvl_shift_o | output | 1 | Level register shift strobe |
| pix_show_o | output | 1 | Rolling-mode per-pixel show strobe |
| commit_o | output | 1 | Global-mode whole-frame commit strobe |
| done_o | output | 1 | One-cycle end-of-load pulse |
| busy_o | output | 1 | Load in progress |
| act_clk_o | output | 1 | Load activity clock, low when idle |

## Verification
The bench builds the sequencer with a 3-row by 4-column array and the default five-bit grey depth. A full binary frame then takes twelve writes and a grey frame takes sixty shifts, so every frame-end event fits in a short run. With three rows and four columns, the row counter wraps at a value that is not a power of two, while the column counter wraps at one that is. Together these cover the column-to-row carry, the final-pixel detection and the frame-end handover into commit and done in both frame kinds and both commit modes.

// File: rtl/frame_load_pkg.sv
package frame_load_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_STREAM = 3'd1,
        ST_LATCH  = 3'd2,
        ST_COMMIT = 3'd3,
        ST_FINISH = 3'd4
    } ld_state_e;

    typedef enum logic {
        FRM_BIN  = 1'b0,
        FRM_GREY = 1'b1
    } frame_kind_e;

    typedef enum logic {
        CMT_ROLL   = 1'b0,
        CMT_GLOBAL = 1'b1
    } commit_mode_e;

    typedef struct packed {
        logic pix_we;
        logic shift;
        logic show;
        logic commit;
        logic done;
        logic bit_val;
    } strobe_t;

    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/fl_addr_ctr.sv
module fl_addr_ctr
    import frame_load_pkg::*;
#(
    parameter int ROWS = 128,
    parameter int COLS = 128
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr_i,
    input  logic                     adv_i,
    output logic [idx_w(ROWS)-1:0]   row_o,
    output logic [idx_w(COLS)-1:0]   col_o,
    output logic                     last_o
);
    localparam int ROW_W = idx_w(ROWS);
    localparam int COL_W = idx_w(COLS);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             col_wrap;

    generate
        if (COLS == 1) begin : g_single_col
            assign col_wrap = 1'b1;
            always_ff @(posedge clk) begin
                col_q <= '0;
            end
        end else begin : g_multi_col
            assign col_wrap = (col_q == COL_LAST);
            always_ff @(posedge clk) begin
                if (rst || clr_i) begin
                    col_q <= '0;
                end else if (adv_i) begin
                    col_q <= col_wrap ? '0 : col_q + 1'b1;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            row_q <= '0;
        end else if (adv_i && col_wrap) begin
            row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
        end
    end

    assign row_o  = row_q;
    assign col_o  = col_q;
    assign last_o = col_wrap && (row_q == ROW_LAST);

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !clr_i && !last_o) |=>
            ((col_o == $past(col_o) + 1'b1 && row_o == $past(row_o)) ||
             (col_o == '0 && row_o == $past(row_o) + 1'b1)));

    // R2
    addr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_i && last_o) |=> (row_o == '0 && col_o == '0));

endmodule

// File: rtl/fl_bit_ctr.sv
module fl_bit_ctr
    import frame_load_pkg::*;
#(
    parameter int BITS = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic adv_i,
    output logic last_o
);
    localparam int CNT_W = idx_w(BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BITS - 1);

    generate
        if (BITS == 1) begin : g_one_bit
            assign last_o = 1'b1;
        end else begin : g_multi_bit
            logic [CNT_W-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst || clr_i) begin
                    cnt_q <= '0;
                end else if (adv_i) begin
                    cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
                end
            end
            assign last_o = (cnt_q == CNT_LAST);

            // R3
            bit_cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
                (adv_i && !clr_i && last_o) |=> !last_o);
        end
    endgenerate

endmodule

// File: rtl/fl_act_clk.sv
module fl_act_clk (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic act_o
);
    logic act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
        end else begin
            act_q <= run_i ? ~act_q : 1'b0;
        end
    end

    assign act_o = act_q;

    // R9
    act_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        run_i |=> (act_o != $past(act_o)));

    // R9
    act_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !act_o);

endmodule

// File: rtl/fl_ctrl.sv
module fl_ctrl
    import frame_load_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        grey_i,
    input  logic        global_i,
    input  logic        s_valid_i,
    input  logic        s_data_i,
    input  logic        pix_last_i,
    input  logic        bit_last_i,
    output logic        ready_o,
    output logic        busy_o,
    output logic        cnt_clr_o,
    output logic        addr_adv_o,
    output logic        bit_adv_o,
    output frame_kind_e kind_o,
    output strobe_t     strb_o
);
    ld_state_e    st_q, st_d;
    frame_kind_e  kind_q;
    commit_mode_e mode_q;
    strobe_t      strb_q, strb_d;
    logic         beat;
    logic         roll;

    assign ready_o = (st_q == ST_STREAM);
    assign busy_o  = (st_q != ST_IDLE);
    assign beat    = ready_o && s_valid_i;
    assign roll    = (mode_q == CMT_ROLL);

    always_comb begin
        st_d       = st_q;
        strb_d     = '0;
        cnt_clr_o  = 1'b0;
        addr_adv_o = 1'b0;
        bit_adv_o  = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    st_d      = ST_STREAM;
                    cnt_clr_o = 1'b1;
                end
            end
            ST_STREAM: begin
                if (beat) begin
                    strb_d.bit_val = s_data_i;
                    if (kind_q == FRM_GREY) begin
                        strb_d.shift = 1'b1;
                        bit_adv_o    = 1'b1;
                        if (bit_last_i) begin
                            st_d = ST_LATCH;
                        end
                    end else begin
                        strb_d.pix_we = 1'b1;
                        strb_d.show   = roll;
                        addr_adv_o    = 1'b1;
                        if (pix_last_i) begin
                            st_d = roll ? ST_FINISH : ST_COMMIT;
                        end
                    end
                end
            end
            ST_LATCH: begin
                strb_d.pix_we = 1'b1;
                strb_d.show   = roll;
                addr_adv_o    = 1'b1;
                if (pix_last_i) begin
                    st_d = roll ? ST_FINISH : ST_COMMIT;
                end else begin
                    st_d = ST_STREAM;
                end
            end
            ST_COMMIT: begin
                strb_d.commit = 1'b1;
                st_d          = ST_FINISH;
            end
            ST_FINISH: begin
                strb_d.done = 1'b1;
                st_d        = ST_IDLE;
            end
            default: begin
                st_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            strb_q <= '0;
            kind_q <= FRM_BIN;
            mode_q <= CMT_ROLL;
        end else begin
            st_q   <= st_d;
            strb_q <= strb_d;
            if (st_q == ST_IDLE && start_i) begin
                kind_q <= frame_kind_e'(grey_i);
                mode_q <= commit_mode_e'(global_i);
            end
        end
    end

    assign kind_o = kind_q;
    assign strb_o = strb_q;

    // R3
    lvl_write_after_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (strb_q.pix_we && kind_q == FRM_GREY) |-> $past(strb_q.shift));

    // R5
    overhead_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (strb_q.pix_we && kind_q == FRM_GREY) |-> !$past(ready_o));

    // R6
    show_only_roll_chk: assert property (@(posedge clk) disable iff (rst)
        strb_q.show |-> (strb_q.pix_we && mode_q == CMT_ROLL));

    // R7
    commit_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        strb_q.commit |-> ($past(strb_q.pix_we) && mode_q == CMT_GLOBAL));

    // R12
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        strb_q.done |=> !strb_q.done);

    // R12
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        strb_q.done |-> !busy_o);

    // R5
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |=> !(strb_q.pix_we || strb_q.shift));

endmodule

// File: rtl/frame_load_seq.sv
module frame_load_seq
    import frame_load_pkg::*;
#(
    parameter int ROWS      = 128,
    parameter int COLS      = 128,
    parameter int GREY_BITS = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic                   grey_i,
    input  logic                   global_i,
    input  logic                   s_valid_i,
    input  logic                   s_data_i,
    output logic                   s_ready_o,
    output logic                   pix_we_o,
    output logic [idx_w(ROWS)-1:0] pix_row_o,
    output logic [idx_w(COLS)-1:0] pix_col_o,
    output logic                   wr_bit_o,
    output logic                   tgt_lvl_o,
    output logic                   lvl_shift_o,
    output logic                   pix_show_o,
    output logic                   commit_o,
    output logic                   done_o,
    output logic                   busy_o,
    output logic                   act_clk_o
);
    localparam int ROW_W = idx_w(ROWS);
    localparam int COL_W = idx_w(COLS);

    logic             cnt_clr, addr_adv, bit_adv;
    logic             pix_last, bit_last;
    logic [ROW_W-1:0] row_cur, row_q;
    logic [COL_W-1:0] col_cur, col_q;
    frame_kind_e      kind;
    strobe_t          strb;

    fl_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .grey_i     (grey_i),
        .global_i   (global_i),
        .s_valid_i  (s_valid_i),
        .s_data_i   (s_data_i),
        .pix_last_i (pix_last),
        .bit_last_i (bit_last),
        .ready_o    (s_ready_o),
        .busy_o     (busy_o),
        .cnt_clr_o  (cnt_clr),
        .addr_adv_o (addr_adv),
        .bit_adv_o  (bit_adv),
        .kind_o     (kind),
        .strb_o     (strb)
    );

    fl_addr_ctr #(.ROWS(ROWS), .COLS(COLS)) u_addr (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (cnt_clr),
        .adv_i  (addr_adv),
        .row_o  (row_cur),
        .col_o  (col_cur),
        .last_o (pix_last)
    );

    fl_bit_ctr #(.BITS(GREY_BITS)) u_bits (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (cnt_clr),
        .adv_i  (bit_adv),
        .last_o (bit_last)
    );

    fl_act_clk u_act (
        .clk   (clk),
        .rst   (rst),
        .run_i (busy_o),
        .act_o (act_clk_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
            col_q <= '0;
        end else if (addr_adv) begin
            row_q <= row_cur;
            col_q <= col_cur;
        end
    end

    assign pix_we_o    = strb.pix_we;
    assign pix_row_o   = row_q;
    assign pix_col_o   = col_q;
    assign wr_bit_o    = strb.bit_val;
    assign tgt_lvl_o   = (kind == FRM_GREY);
    assign lvl_shift_o = strb.shift;
    assign pix_show_o  = strb.show;
    assign commit_o    = strb.commit;
    assign done_o      = strb.done;

    // R3
    shift_target_chk: assert property (@(posedge clk) disable iff (rst)
        lvl_shift_o |-> (tgt_lvl_o && !pix_we_o));

endmodule

// File: tb/frame_load_seq_bench.sv
`timescale 1ns/1ps
module frame_load_seq_bench;
    localparam int ROWS = 3;
    localparam int COLS = 4;
    localparam int GB   = 5;
    localparam int NPIX = ROWS * COLS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, grey_i = 1'b0, global_i = 1'b0;
    logic s_valid_i = 1'b0, s_data_i = 1'b0;
    logic s_ready_o, pix_we_o, wr_bit_o, tgt_lvl_o, lvl_shift_o;
    logic pix_show_o, commit_o, done_o, busy_o, act_clk_o;
    logic [1:0] pix_row_o;
    logic [1:0] pix_col_o;

    always #2.5 clk = ~clk;

    frame_load_seq #(.ROWS(ROWS), .COLS(COLS), .GREY_BITS(GB)) u_frame_load_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .grey_i(grey_i), .global_i(global_i),
        .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_ready_o(s_ready_o),
        .pix_we_o(pix_we_o), .pix_row_o(pix_row_o), .pix_col_o(pix_col_o),
        .wr_bit_o(wr_bit_o), .tgt_lvl_o(tgt_lvl_o), .lvl_shift_o(lvl_shift_o),
        .pix_show_o(pix_show_o), .commit_o(commit_o), .done_o(done_o),
        .busy_o(busy_o), .act_clk_o(act_clk_o)
    );

    int n_chk = 0, n_fail = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor logs
    int mcyc = 0;
    bit rdy_hist [1024];
    int wrow [64], wcol [64], wbit [64], wtgt [64], wshow [64], wcyc [64];
    int sbit [512], scyc [512];
    int n_w = 0, n_s = 0, n_c = 0, n_done = 0, ccyc = 0, dcyc = 0;
    int busy_at_done = 0, busy_before_done = 0, act_bad = 0;
    logic prev_busy = 1'b0, prev_act = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            mcyc++;
            rdy_hist[mcyc % 1024] = s_ready_o;
            if (pix_we_o && n_w < 64) begin
                wrow[n_w] = int'(pix_row_o);
                wcol[n_w] = int'(pix_col_o);
                wbit[n_w] = int'(wr_bit_o);
                wtgt[n_w] = int'(tgt_lvl_o);
                wshow[n_w] = int'(pix_show_o);
                wcyc[n_w] = mcyc;
                n_w++;
            end
            if (lvl_shift_o && n_s < 512) begin
                sbit[n_s] = int'(wr_bit_o);
                scyc[n_s] = mcyc;
                n_s++;
            end
            if (commit_o) begin n_c++; ccyc = mcyc; end
            if (done_o) begin
                n_done++; dcyc = mcyc;
                busy_at_done = int'(busy_o);
                busy_before_done = int'(prev_busy);
            end
            if (prev_busy) begin
                if (act_clk_o === prev_act) act_bad++;
            end else if (act_clk_o !== 1'b0) begin
                act_bad++;
            end
            prev_busy = busy_o;
            prev_act = act_clk_o;
        end
    end

    function automatic int bin_px(input int p, input int seed);
        return ((p * 5 + seed) >> 1) & 1;
    endfunction

    function automatic int grey_px(input int p, input int seed);
        return (p * 13 + seed) % 32;
    endfunction

    task automatic send_bit(input int b);
        bit acc;
        s_valid_i = 1'b1;
        s_data_i = b[0];
        while (1) begin
            acc = s_ready_o;
            @(negedge clk);
            if (acc) break;
        end
        s_valid_i = 1'b0;
    endtask

    task automatic pulse_start(input bit g, input bit gl);
        start_i = 1'b1; grey_i = g; global_i = gl;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!s_ready_o && !busy_o && !act_clk_o, "R1 ready/busy/act after reset",
              int'(s_ready_o) + int'(busy_o) + int'(act_clk_o), 0);
        check(!pix_we_o && !lvl_shift_o && !pix_show_o && !commit_o && !done_o,
              "R1 strobes after reset",
              int'(pix_we_o) + int'(lvl_shift_o) + int'(pix_show_o) + int'(commit_o) + int'(done_o), 0);
    endtask

    // R5: beats offered while idle are not taken and cause no strobes
    task automatic t_idle_beats();
        int rdy_seen = 0;
        n_w = 0; n_s = 0;
        s_valid_i = 1'b1; s_data_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            rdy_seen += int'(s_ready_o);
            @(negedge clk);
        end
        s_valid_i = 1'b0;
        @(negedge clk);
        check(rdy_seen == 0, "R5 ready while idle", rdy_seen, 0);
        check(n_w == 0 && n_s == 0, "R5 strobes from idle beats", n_w + n_s, 0);
    endtask

    task automatic run_frame(input bit g, input bit gl, input bit stall, input bit mid_start,
                             input int seed);
        int act0, bad, last;
        n_w = 0; n_s = 0; n_c = 0; n_done = 0;
        act0 = act_bad;
        pulse_start(g, gl);
        for (int p = 0; p < NPIX; p++) begin
            if (g) begin
                for (int k = GB - 1; k >= 0; k--) send_bit((grey_px(p, seed) >> k) & 1);
            end else begin
                send_bit(bin_px(p, seed));
            end
            if (stall && (p % 2 == 1)) repeat (2) @(negedge clk);
            if (mid_start && p == 1) pulse_start(!g, !gl);
        end
        grey_i = 1'b0; global_i = 1'b0;
        for (int i = 0; i < 200 && n_done == 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);

        check(n_done == 1, "R12 one done pulse per load", n_done, 1);
        check(busy_at_done == 0 && busy_before_done == 1, "R12 busy falls at done",
              busy_at_done * 2 + busy_before_done, 1);
        check(n_w == NPIX, g ? "R3 pixel level writes" : "R2 pixel writes", n_w, NPIX);
        if (n_w != NPIX) return;
        last = n_w - 1;

        bad = 0;
        for (int i = 0; i < NPIX; i++)
            if (wrow[i] != i / COLS || wcol[i] != i % COLS) bad++;
        check(bad == 0, "R2 row-major addresses", bad, 0);

        bad = 0;
        for (int i = 0; i < NPIX; i++) begin
            if (wtgt[i] != int'(g)) bad++;
            if (!g && wbit[i] != bin_px(i, seed)) bad++;
        end
        if (mid_start)   check(bad == 0, "R11 kind kept despite second start", bad, 0);
        else if (stall)  check(bad == 0, "R10 data intact across gaps", bad, 0);
        else             check(bad == 0, g ? "R3 write target" : "R2 write bits/target", bad, 0);

        if (g) begin
            check(n_s == NPIX * GB, "R3 shift strobe count", n_s, NPIX * GB);
            bad = 0;
            for (int p = 0; p < NPIX && n_s == NPIX * GB; p++)
                for (int k = 0; k < GB; k++)
                    if (sbit[p * GB + k] != ((grey_px(p, seed) >> (GB - 1 - k)) & 1)) bad++;
            check(bad == 0, "R3 shift bits MSB first", bad, 0);
            bad = 0;
            for (int p = 0; p < NPIX && n_s == NPIX * GB; p++) begin
                if (wcyc[p] != scyc[p * GB + GB - 1] + 1) bad++;
                if (rdy_hist[(wcyc[p] - 1) % 1024]) bad++;
            end
            check(bad == 0, "R5 overhead cycle with ready low before level write", bad, 0);
        end

        if (!stall && !mid_start) begin
            bad = 0;
            for (int i = 1; i < NPIX; i++)
                if (wcyc[i] - wcyc[i - 1] != (g ? GB + 1 : 1)) bad++;
            check(bad == 0, "R4 pixel write spacing", bad, 0);
        end

        bad = 0;
        for (int i = 0; i < NPIX; i++)
            if (wshow[i] != int'(!gl)) bad++;
        check(bad == 0, gl ? "R7 no show strobes in global" : "R6 show with each write", bad, 0);

        if (gl) begin
            check(n_c == 1, "R7 single commit", n_c, 1);
            check(ccyc == wcyc[last] + 1 && dcyc == ccyc + 1, "R7 commit/done timing",
                  dcyc - wcyc[last], 2);
        end else begin
            check(n_c == 0, "R6 no commit in rolling", n_c, 0);
            check(dcyc == wcyc[last] + 1, "R8 done after last write", dcyc - wcyc[last], 1);
        end
        check(act_bad == act0, "R9 activity clock", act_bad - act0, 0);
    endtask

    bit finished = 1'b0;

    initial begin
        t_reset();
        t_idle_beats();
        run_frame(1'b0, 1'b0, 1'b0, 1'b0, 3);
        run_frame(1'b0, 1'b1, 1'b1, 1'b0, 6);
        run_frame(1'b1, 1'b0, 1'b0, 1'b0, 1);
        run_frame(1'b1, 1'b1, 1'b0, 1'b0, 9);
        run_frame(1'b1, 1'b1, 1'b1, 1'b1, 4);
        run_frame(1'b0, 1'b0, 1'b0, 1'b1, 2);
        t_idle_beats();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", mcyc, 0);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule